// File: doc/BRIEF.md
# Ripple-Carry Bit-Slice ALU

This block is a parameterised arithmetic/logic unit made from a chain of identical one-bit cells. Each cell handles one operand bit pair. The carry leaves the least significant cell and travels through every cell in turn up to the most significant one. Three control inputs reach every cell unchanged: a mode bit and a two-bit select.

Inside each cell, select bit 0 decides whether the A bit is inverted. Select bit 1 decides whether the B bit takes part at all. One exclusive-OR/AND structure therefore gives four arithmetic and four logic operations.

The unit is purely combinational. Results appear at the outputs once the carry has settled through the whole chain. Its only flag is the carry out of the top cell.

Top module: `rc_alu`

## Requirements
- R1: With mode=1 (arithmetic) and sel=2'b00, {cout, f} equals A + cin.
- R2: With mode=1 and sel=2'b01, {cout, f} equals ~A + cin, where ~A is the WIDTH-bit complement.
- R3: With mode=1 and sel=2'b10, {cout, f} equals A + B + cin.
- R4: With mode=1 and sel=2'b11, {cout, f} equals ~A + B + cin.
- R5: With mode=0 (logic), f equals A, ~A, A|B or ~A|B for sel = 2'b00, 2'b01, 2'b10, 2'b11 respectively.
- R6: With mode=0, cout is 0 for every operand, select and carry-in value.
- R7: With mode=0, cin has no effect on f.
- R8: A carry generated or propagated at bit 0 travels the full width. A=all ones with cin=1 under sel=2'b00 gives f=0 and cout=1.
- R9: The width is the parameter WIDTH (default 8). sel[0] inverts A, sel[1] gates B, and the behaviour above holds at any WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B |
| cin | input | 1 | Carry into bit 0 |
| mode | input | 1 | 1 = arithmetic, 0 = logic |
| sel | input | 2 | sel[1] gates B, sel[0] inverts A |
| f | output | WIDTH | Result |
| cout | output | 1 | Carry out of the most significant cell |

## Verification
Immediate assertions are evaluated whenever the inputs change. They compare the whole chained result against a vector-level sum in arithmetic mode and against a vector-level OR in logic mode. They also check that logic mode leaves the top carry and every internal carry at zero.

Only the bench's scenarios can show two further properties. The first is that cin leaves f untouched in logic mode, which needs the same operands applied with both carry values. The second is that a carry really crosses all cells. The bench also confirms the parameter by driving a narrow instance through every input combination.

// File: rtl/rc_alu_pkg.sv
package rc_alu_pkg;
  localparam logic MODE_LOGIC = 1'b0;
  localparam logic MODE_ARITH = 1'b1;

  typedef enum logic [1:0] {
    SEL_A     = 2'b00,
    SEL_NOT_A = 2'b01,
    SEL_A_B   = 2'b10,
    SEL_NA_B  = 2'b11
  } alu_sel_e;
endpackage

// File: rtl/rc_alu_slice.sv
module rc_alu_slice (
  input  logic a_bit,
  input  logic b_bit,
  input  logic c_in,
  input  logic arith,
  input  logic gate_b,
  input  logic inv_a,
  output logic f_bit,
  output logic c_out
);
  logic p_term;
  logic g_term;

  assign p_term = a_bit ^ inv_a;
  assign g_term = gate_b & b_bit;

  always_comb begin
    if (arith) begin
      f_bit = c_in ^ p_term ^ g_term;
      c_out = (c_in & (p_term ^ g_term)) | (g_term & p_term);
    end else begin
      f_bit = p_term | g_term;
      c_out = 1'b0;
    end
  end
endmodule

// File: rtl/rc_alu_chain.sv
module rc_alu_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             mode,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] f,
  output logic             cout
);
  localparam int NCARRY = WIDTH + 1;

  logic [NCARRY-1:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    rc_alu_slice u_cell (
      .a_bit  (a[i]),
      .b_bit  (b[i]),
      .c_in   (carry[i]),
      .arith  (mode),
      .gate_b (sel[1]),
      .inv_a  (sel[0]),
      .f_bit  (f[i]),
      .c_out  (carry[i+1])
    );
  end

  assign cout = carry[WIDTH];

  // R6
  always_comb begin
    if (!mode) begin
      logic_carry_clear_chk: assert (carry[NCARRY-1:1] == '0)
        else $error("internal carry set in logic mode");
    end
  end
endmodule

// File: rtl/rc_alu.sv
module rc_alu #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             mode,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] f,
  output logic             cout
);
  import rc_alu_pkg::*;

  localparam int SUMW = WIDTH + 1;

  rc_alu_chain #(.WIDTH(WIDTH)) u_chain (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .mode (mode),
    .sel  (sel),
    .f    (f),
    .cout (cout)
  );

  logic [WIDTH-1:0] opnd_a;
  logic [WIDTH-1:0] opnd_b;
  logic [SUMW-1:0]  vec_sum;
  logic [WIDTH-1:0] vec_or;

  always_comb begin
    opnd_a  = (alu_sel_e'(sel) inside {SEL_NOT_A, SEL_NA_B}) ? ~a : a;
    opnd_b  = (alu_sel_e'(sel) inside {SEL_A_B, SEL_NA_B}) ? b : '0;
    vec_sum = {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, cin};
    vec_or  = opnd_a | opnd_b;
  end

  always_comb begin
    if (mode == MODE_ARITH) begin
      // R1 R2 R3 R4 R8
      arith_sum_chk: assert ({cout, f} == vec_sum)
        else $error("chained sum differs from vector sum");
    end
    if (mode == MODE_LOGIC) begin
      // R5
      logic_result_chk: assert (f == vec_or)
        else $error("logic result differs");
      // R6
      logic_cout_chk: assert (cout == 1'b0)
        else $error("carry out set in logic mode");
    end
  end
endmodule

// File: tb/tb_rc_alu.sv
module tb_rc_alu;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;

  logic [7:0] a8, b8, f8;
  logic [3:0] a4, b4, f4;
  logic cin, mode, cout8, cout4;
  logic [1:0] sel;

  rc_alu #(.WIDTH(8)) dut (
    .a(a8), .b(b8), .cin(cin), .mode(mode), .sel(sel), .f(f8), .cout(cout8));
  rc_alu #(.WIDTH(4)) dut_small (
    .a(a4), .b(b4), .cin(cin), .mode(mode), .sel(sel), .f(f4), .cout(cout4));

  function automatic string tag_of(logic m, logic [1:0] s);
    if (!m) return "R5";
    case (s)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic void ref_model(int w, int av, int bv, int ci, logic m,
                                    logic [1:0] s, output int fe, output int ce);
    int mask = (1 << w) - 1;
    int oa = s[0] ? (~av & mask) : av;
    int ob = s[1] ? bv : 0;
    int sum;
    if (m) begin
      sum = oa + ob + ci;
      fe = sum & mask;
      ce = (sum >> w) & 1;
    end else begin
      fe = oa | ob;
      ce = 0;
    end
  endfunction

  task automatic apply_check(int w, int av, int bv, logic ci, logic m,
                             logic [1:0] s, string extra);
    int fe, ce, fa, ca;
    @(negedge clk);
    cin = ci; mode = m; sel = s;
    if (w == 8) begin a8 = av[7:0]; b8 = bv[7:0]; end
    else begin a4 = av[3:0]; b4 = bv[3:0]; end
    #1;
    ref_model(w, av, bv, int'(ci), m, s, fe, ce);
    fa = (w == 8) ? int'(f8) : int'(f4);
    ca = (w == 8) ? int'(cout8) : int'(cout4);
    vectors++;
    if (fa != fe) begin
      miscompares++;
      $display("FAIL %s%s w=%0d f actual=%0h expected=%0h", tag_of(m, s), extra, w, fa, fe);
    end
    if (ca != ce) begin
      miscompares++;
      $display("FAIL %s%s w=%0d cout actual=%0d expected=%0d",
               m ? tag_of(m, s) : "R6", extra, w, ca, ce);
    end
  endtask

  // all-zero idle vector (R1)
  task automatic t_idle();
    apply_check(8, 0, 0, 1'b0, 1'b1, 2'b00, " idle");
    apply_check(4, 0, 0, 1'b0, 1'b0, 2'b00, " idle");
  endtask

  // R1 R2 R3 R4 R9: every arithmetic input on the narrow instance
  task automatic t_arith_exhaustive();
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int x = 0; x < 16; x++)
          for (int y = 0; y < 16; y++)
            apply_check(4, x, y, c[0], 1'b1, s[1:0], " R9");
  endtask

  // R5 R6 R9: every logic input on the narrow instance
  task automatic t_logic_exhaustive();
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int x = 0; x < 16; x++)
          for (int y = 0; y < 16; y++)
            apply_check(4, x, y, c[0], 1'b0, s[1:0], " R6");
  endtask

  // R7: cin toggled with the same operands in logic mode
  task automatic t_cin_ignored();
    logic [7:0] f_lo;
    for (int s = 0; s < 4; s++) begin
      apply_check(8, 8'h5A, 8'hC3, 1'b0, 1'b0, s[1:0], " R7");
      f_lo = f8;
      apply_check(8, 8'h5A, 8'hC3, 1'b1, 1'b0, s[1:0], " R7");
      vectors++;
      if (f8 != f_lo) begin
        miscompares++;
        $display("FAIL R7 f with cin=1 actual=%0h expected=%0h", f8, f_lo);
      end
    end
  endtask

  // R8: carry crossing the whole width
  task automatic t_ripple_full();
    apply_check(8, 8'hFF, 0, 1'b1, 1'b1, 2'b00, " R8");
    apply_check(8, 8'h00, 0, 1'b1, 1'b1, 2'b01, " R8");
    apply_check(8, 8'h01, 8'hFF, 1'b0, 1'b1, 2'b10, " R8");
    apply_check(8, 8'h00, 8'h00, 1'b1, 1'b1, 2'b11, " R8");
  endtask

  // R9: random vectors at the default width
  task automatic t_random_wide();
    for (int k = 0; k < 3000; k++)
      apply_check(8, int'($urandom_range(255)), int'($urandom_range(255)),
                  1'($urandom_range(1)), 1'($urandom_range(1)),
                  2'($urandom_range(3)), " R9");
  endtask

  initial begin
    a8 = '0; b8 = '0; a4 = '0; b4 = '0; cin = 1'b0; mode = 1'b0; sel = 2'b00;
    repeat (3) @(posedge clk);
    t_idle();
    t_arith_exhaustive();
    t_logic_exhaustive();
    t_cin_ignored();
    t_ripple_full();
    t_random_wide();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule